// File: doc/BRIEF.md
# Associative Record Cache with FIFO/LRU Replacement

This block keeps a small set of security database records on chip, in front of a slower external record store. Each query presents a key built from address selectors. The key is compared against every valid entry at once. On a hit, the block returns the matching entry's index and payload. On a miss, it raises a request carrying the key toward an external search engine. That engine later hands back a record through the fill port, and the record is installed in the cache.

Empty entries are used first. Once every entry is valid, a fill overwrites a victim, and the victim is chosen by a policy input that can change at run time:

- **FIFO**: the victim is the entry loaded longest ago.
- **LRU**: the victim is the entry touched longest ago.

A separate write port updates the payload of a cached entry and marks it modified. When a modified victim is overwritten, its key and old payload are emitted once so they can be stored back. A clean victim is dropped without any output. Key width, payload width and depth are parameters, and the depth must be a power of two.

Top module: `assoc_rec_cache`

## Requirements
- R1: After reset every entry is invalid, all result, miss and write-back outputs are low, and the first lookup of any key misses.
- R2: A lookup presented at one clock edge is answered exactly one edge later: `res_valid_o` high for one cycle, and on a hit `res_hit_o`=1 with the entry index and its payload.
- R3: A lookup of a key held in no valid entry gives `res_hit_o`=0 and, in the same cycle, `miss_req_o`=1 with `miss_key_o` equal to the looked-up key.
- R4: A fill while any entry is invalid installs the record, clean, in the lowest-numbered invalid entry; no replacement occurs until all entries are valid.
- R5: With `policy_i`=0 (FIFO), a fill into a full cache replaces the entry loaded earliest, whatever hits came after.
- R6: With `policy_i`=1 (LRU), a fill into a full cache replaces the entry whose last lookup hit or fill is oldest. A lookup hit refreshes that entry's recency; a write does not.
- R7: A write whose key matches a valid entry replaces that entry's payload and marks it modified. A write whose key matches nothing changes nothing.
- R8: When a fill overwrites a valid, modified entry, `wb_valid_o` pulses one cycle after the fill edge, carrying the victim's key and payload. A clean victim gives no pulse.
- R9: When several valid entries hold the lookup key, the lowest index is reported.
- R10: A lookup and a write to the same key in one cycle: the lookup returns the payload from before the write, and later lookups return the new one.
- R11: Load order and recency are both tracked at all times, so changing `policy_i` takes effect at the very next fill.
- R12: A lookup and a fill in one cycle: the lookup is answered from the contents before the fill, and the victim is chosen from the order before that cycle's hit refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| policy_i | input | 1 | Victim policy: 0 = FIFO, 1 = LRU |
| lk_valid_i | input | 1 | Lookup request |
| lk_key_i | input | KEY_W | Lookup key |
| wr_valid_i | input | 1 | Payload update request |
| wr_key_i | input | KEY_W | Key of the entry to update |
| wr_data_i | input | DATA_W | New payload |
| fill_valid_i | input | 1 | Install a record returned by the search engine |
| fill_key_i | input | KEY_W | Key of the installed record |
| fill_data_i | input | DATA_W | Payload of the installed record |
| res_valid_o | output | 1 | Lookup result valid |
| res_hit_o | output | 1 | Lookup hit |
| res_idx_o | output | $clog2(DEPTH) | Index of the hit entry |
| res_data_o | output | DATA_W | Payload of the hit entry (zero on a miss) |
| miss_req_o | output | 1 | Search request toward external memory |
| miss_key_o | output | KEY_W | Key to search for |
| wb_valid_o | output | 1 | Modified victim write-back |
| wb_key_o | output | KEY_W | Victim key |
| wb_data_o | output | DATA_W | Victim payload |

## Verification
Two pairs of functions can meet in one cycle.

- **Lookup and write to the same key.** The bench drives both ports on one edge. It expects the result to carry the old payload, and the next lookup to carry the new one.
- **Lookup hit and fill under LRU.** The bench looks up the current LRU entry while filling a new record. It expects a hit on the old contents, and expects the victim to be that same entry, chosen before the refresh. A follow-up lookup then shows the old key gone and the new key at that index.

Dirty write-back is checked in the same run: a written entry is aged until it becomes the victim, and the bench then expects its key and updated payload on the write-back port.

// File: rtl/arc_pkg.sv
`timescale 1ns/1ps
package arc_pkg;
   typedef enum logic {
      POL_FIFO = 1'b0,
      POL_LRU  = 1'b1
   } policy_e;
endpackage

// File: rtl/arc_match.sv
`timescale 1ns/1ps
// Parallel key compare over all entries, lowest matching index wins.
module arc_match #(
   parameter  int KEY_W = 64,
   parameter  int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] vld,
   input  logic [KEY_W-1:0] tags [DEPTH],
   input  logic [KEY_W-1:0] key,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);
   logic [DEPTH-1:0] eq;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
         assign eq[g] = vld[g] && (tags[g] == key);
      end
   endgenerate

   always_comb begin
      hit = |eq;
      idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (eq[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/arc_age.sv
`timescale 1ns/1ps
// Order tracker: ages form a permutation of 0..DEPTH-1, 0 = newest.
// Two touches per cycle, applied t0 then t1.
module arc_age #(
   parameter  int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             t0_en,
   input  logic [IDX_W-1:0] t0_idx,
   input  logic             t1_en,
   input  logic [IDX_W-1:0] t1_idx,
   output logic [IDX_W-1:0] age_o [DEPTH]
);
   logic [IDX_W-1:0] age_q [DEPTH];
   logic [IDX_W-1:0] mid   [DEPTH];
   logic [IDX_W-1:0] nxt   [DEPTH];
   logic [IDX_W-1:0] ref0, ref1;
   logic [DEPTH-1:0] is_new, is_old;

   always_comb begin
      ref0 = age_q[t0_idx];
      for (int i = 0; i < DEPTH; i++) begin
         mid[i] = age_q[i];
         if (t0_en) begin
            if (IDX_W'(i) == t0_idx)  mid[i] = '0;
            else if (age_q[i] < ref0) mid[i] = age_q[i] + 1'b1;
         end
      end
   end

   always_comb begin
      ref1 = mid[t1_idx];
      for (int i = 0; i < DEPTH; i++) begin
         nxt[i] = mid[i];
         if (t1_en) begin
            if (IDX_W'(i) == t1_idx) nxt[i] = '0;
            else if (mid[i] < ref1)  nxt[i] = mid[i] + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) age_q[i] <= IDX_W'(DEPTH - 1 - i);
      end else begin
         age_q <= nxt;
      end
   end

   assign age_o = age_q;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_flag
         assign is_new[g] = (age_q[g] == '0);
         assign is_old[g] = (age_q[g] == IDX_W'(DEPTH - 1));
      end
   endgenerate

   // R11: both orders stay a full permutation, one newest and one oldest
   a_r11_one_newest: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(is_new) == 1);
   a_r11_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(is_old) == 1);
   a_r6_touch_newest: assert property (@(posedge clk) disable iff (!rst_n)
      t1_en |=> age_q[$past(t1_idx)] == '0);
endmodule

// File: rtl/arc_victim.sv
`timescale 1ns/1ps
// Victim choice: lowest invalid entry first, else oldest under the policy.
module arc_victim #(
   parameter  int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  arc_pkg::policy_e policy,
   input  logic [DEPTH-1:0] vld,
   input  logic [IDX_W-1:0] fifo_age [DEPTH],
   input  logic [IDX_W-1:0] lru_age  [DEPTH],
   output logic [IDX_W-1:0] idx
);
   logic [IDX_W-1:0] sel_age [DEPTH];
   logic [IDX_W-1:0] free_idx, old_idx;
   logic             any_free;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_sel
         assign sel_age[g] = (policy == arc_pkg::POL_LRU) ? lru_age[g] : fifo_age[g];
      end
   endgenerate

   always_comb begin
      free_idx = '0;
      any_free = 1'b0;
      old_idx  = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!vld[i]) begin
            free_idx = IDX_W'(i);
            any_free = 1'b1;
         end
         if (sel_age[i] == IDX_W'(DEPTH - 1)) old_idx = IDX_W'(i);
      end
      idx = any_free ? free_idx : old_idx;
   end

   // R4: while a free entry exists, the victim is never a valid one
   a_r4_free_first: assert property (@(posedge clk) disable iff (!rst_n)
      (~&vld) |-> !vld[idx]);
endmodule

// File: rtl/assoc_rec_cache.sv
`timescale 1ns/1ps
module assoc_rec_cache #(
   parameter  int KEY_W  = 64,
   parameter  int DATA_W = 232,
   parameter  int DEPTH  = 64,
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              policy_i,
   input  logic              lk_valid_i,
   input  logic [KEY_W-1:0]  lk_key_i,
   input  logic              wr_valid_i,
   input  logic [KEY_W-1:0]  wr_key_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              fill_valid_i,
   input  logic [KEY_W-1:0]  fill_key_i,
   input  logic [DATA_W-1:0] fill_data_i,
   output logic              res_valid_o,
   output logic              res_hit_o,
   output logic [IDX_W-1:0]  res_idx_o,
   output logic [DATA_W-1:0] res_data_o,
   output logic              miss_req_o,
   output logic [KEY_W-1:0]  miss_key_o,
   output logic              wb_valid_o,
   output logic [KEY_W-1:0]  wb_key_o,
   output logic [DATA_W-1:0] wb_data_o
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("assoc_rec_cache: DEPTH must be a power of two, at least 2");
      end
      if (KEY_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("assoc_rec_cache: KEY_W and DATA_W must be positive");
      end
   endgenerate

   arc_pkg::policy_e  pol;
   logic [DEPTH-1:0]  vld_q, dirty_q;
   logic [KEY_W-1:0]  tag_q [DEPTH];
   logic [DATA_W-1:0] dat_q [DEPTH];
   logic [IDX_W-1:0]  fifo_age [DEPTH];
   logic [IDX_W-1:0]  lru_age  [DEPTH];
   logic              lk_hit, wr_hit;
   logic [IDX_W-1:0]  lk_idx, wr_idx, vic_idx;
   logic              lk_touch;

   assign pol      = arc_pkg::policy_e'(policy_i);
   assign lk_touch = lk_valid_i && lk_hit;

   arc_match #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_lk_match (
      .vld(vld_q), .tags(tag_q), .key(lk_key_i), .hit(lk_hit), .idx(lk_idx));

   arc_match #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_wr_match (
      .vld(vld_q), .tags(tag_q), .key(wr_key_i), .hit(wr_hit), .idx(wr_idx));

   // load order: only fills count
   arc_age #(.DEPTH(DEPTH)) u_fifo_age (
      .clk(clk), .rst_n(rst_n),
      .t0_en(1'b0), .t0_idx('0),
      .t1_en(fill_valid_i), .t1_idx(vic_idx),
      .age_o(fifo_age));

   // recency: lookup hits then fills
   arc_age #(.DEPTH(DEPTH)) u_lru_age (
      .clk(clk), .rst_n(rst_n),
      .t0_en(lk_touch), .t0_idx(lk_idx),
      .t1_en(fill_valid_i), .t1_idx(vic_idx),
      .age_o(lru_age));

   arc_victim #(.DEPTH(DEPTH)) u_victim (
      .clk(clk), .rst_n(rst_n), .policy(pol), .vld(vld_q),
      .fifo_age(fifo_age), .lru_age(lru_age), .idx(vic_idx));

   // control state and registered outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q       <= '0;
         dirty_q     <= '0;
         res_valid_o <= 1'b0;
         res_hit_o   <= 1'b0;
         res_idx_o   <= '0;
         res_data_o  <= '0;
         miss_req_o  <= 1'b0;
         miss_key_o  <= '0;
         wb_valid_o  <= 1'b0;
         wb_key_o    <= '0;
         wb_data_o   <= '0;
      end else begin
         res_valid_o <= lk_valid_i;
         res_hit_o   <= lk_touch;
         res_idx_o   <= lk_hit ? lk_idx : '0;
         res_data_o  <= lk_hit ? dat_q[lk_idx] : '0;
         miss_req_o  <= lk_valid_i && !lk_hit;
         miss_key_o  <= lk_key_i;
         wb_valid_o  <= fill_valid_i && vld_q[vic_idx] && dirty_q[vic_idx];
         wb_key_o    <= tag_q[vic_idx];
         wb_data_o   <= dat_q[vic_idx];
         if (wr_valid_i && wr_hit) dirty_q[wr_idx] <= 1'b1;
         if (fill_valid_i) begin
            vld_q[vic_idx]   <= 1'b1;
            dirty_q[vic_idx] <= 1'b0;
         end
      end
   end

   // record storage, no reset needed
   always_ff @(posedge clk) begin
      if (wr_valid_i && wr_hit) dat_q[wr_idx] <= wr_data_i;
      if (fill_valid_i) begin
         tag_q[vic_idx] <= fill_key_i;
         dat_q[vic_idx] <= fill_data_i;
      end
   end

   a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid_i |=> res_valid_o);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid_i |=> !res_valid_o);
   a_r3_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
      miss_req_o |-> res_valid_o && !res_hit_o);
   a_r8_wb_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid_o |-> $past(fill_valid_i));
   a_r7_write_dirty: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_i && wr_hit && !(fill_valid_i && vic_idx == wr_idx)) |=> dirty_q[$past(wr_idx)]);
   a_r4_fill_valid: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid_i |=> vld_q[$past(vic_idx)] && !dirty_q[$past(vic_idx)]);
endmodule

// File: tb/tb_assoc_rec_cache.sv
`timescale 1ns/1ps
module tb_assoc_rec_cache;
   localparam int KW = 8;
   localparam int DW = 16;
   localparam int DP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          policy_i = 1'b0;
   logic          lk_valid_i = 1'b0;
   logic [KW-1:0] lk_key_i = '0;
   logic          wr_valid_i = 1'b0;
   logic [KW-1:0] wr_key_i = '0;
   logic [DW-1:0] wr_data_i = '0;
   logic          fill_valid_i = 1'b0;
   logic [KW-1:0] fill_key_i = '0;
   logic [DW-1:0] fill_data_i = '0;
   logic          res_valid_o, res_hit_o, miss_req_o, wb_valid_o;
   logic [1:0]    res_idx_o;
   logic [DW-1:0] res_data_o, wb_data_o;
   logic [KW-1:0] miss_key_o, wb_key_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   assoc_rec_cache #(.KEY_W(KW), .DATA_W(DW), .DEPTH(DP)) dut (
      .clk(clk), .rst_n(rst_n), .policy_i(policy_i),
      .lk_valid_i(lk_valid_i), .lk_key_i(lk_key_i),
      .wr_valid_i(wr_valid_i), .wr_key_i(wr_key_i), .wr_data_i(wr_data_i),
      .fill_valid_i(fill_valid_i), .fill_key_i(fill_key_i), .fill_data_i(fill_data_i),
      .res_valid_o(res_valid_o), .res_hit_o(res_hit_o), .res_idx_o(res_idx_o),
      .res_data_o(res_data_o), .miss_req_o(miss_req_o), .miss_key_o(miss_key_o),
      .wb_valid_o(wb_valid_o), .wb_key_o(wb_key_o), .wb_data_o(wb_data_o));

   // vector: op(2) key(8) data(16) exp_flag(1) exp_idx(2) exp_data(16)
   // op 0 = lookup (flag = hit), op 1 = fill (flag = write-back expected)
   localparam logic [44:0] VEC [8] = '{
      {2'd0, 8'h11, 16'h0000, 1'b0, 2'd0, 16'h0000},
      {2'd1, 8'h11, 16'h0A11, 1'b0, 2'd0, 16'h0000},
      {2'd1, 8'h22, 16'h0B22, 1'b0, 2'd0, 16'h0000},
      {2'd1, 8'h33, 16'h0C33, 1'b0, 2'd0, 16'h0000},
      {2'd1, 8'h44, 16'h0D44, 1'b0, 2'd0, 16'h0000},
      {2'd0, 8'h33, 16'h0000, 1'b1, 2'd2, 16'h0C33},
      {2'd0, 8'h11, 16'h0000, 1'b1, 2'd0, 16'h0A11},
      {2'd0, 8'h55, 16'h0000, 1'b0, 2'd0, 16'h0000}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_lookup(input logic [KW-1:0] k, input bit eh, input logic [1:0] ei,
                            input logic [DW-1:0] ed, input string req);
      lk_valid_i = 1'b1; lk_key_i = k;
      @(negedge clk);
      lk_valid_i = 1'b0;
      chk(res_valid_o == 1'b1, {req, " res_valid"}, 32'(res_valid_o), 32'd1);
      chk(res_hit_o == eh, {req, " hit"}, 32'(res_hit_o), 32'(eh));
      if (eh) begin
         chk(res_idx_o == ei, {req, " idx"}, 32'(res_idx_o), 32'(ei));
         chk(res_data_o == ed, {req, " data"}, 32'(res_data_o), 32'(ed));
      end else begin
         chk(miss_req_o && miss_key_o == k, {req, " miss key"}, 32'(miss_key_o), 32'(k));
      end
   endtask

   task automatic do_fill(input logic [KW-1:0] k, input logic [DW-1:0] d, input bit ewb,
                          input logic [KW-1:0] ek, input logic [DW-1:0] ed, input string req);
      fill_valid_i = 1'b1; fill_key_i = k; fill_data_i = d;
      @(negedge clk);
      fill_valid_i = 1'b0;
      chk(wb_valid_o == ewb, {req, " wb_valid"}, 32'(wb_valid_o), 32'(ewb));
      if (ewb) begin
         chk(wb_key_o == ek, {req, " wb_key"}, 32'(wb_key_o), 32'(ek));
         chk(wb_data_o == ed, {req, " wb_data"}, 32'(wb_data_o), 32'(ed));
      end
   endtask

   task automatic do_write(input logic [KW-1:0] k, input logic [DW-1:0] d);
      wr_valid_i = 1'b1; wr_key_i = k; wr_data_i = d;
      @(negedge clk);
      wr_valid_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!res_valid_o && !miss_req_o && !wb_valid_o && !res_hit_o, "R1 reset outputs",
          {res_valid_o, miss_req_o, wb_valid_o, res_hit_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: R1 first miss, R4 free-first fills, R2 hits, R3 miss
      for (int v = 0; v < 8; v++) begin
         logic [44:0] e;
         e = VEC[v];
         if (e[44:43] == 2'd0)
            do_lookup(e[42:35], e[18], e[17:16], e[15:0], e[18] ? "R2 table hit" : "R3 R1 table miss");
         else
            do_fill(e[42:35], e[34:19], e[18], 8'h00, e[15:0], "R4 table fill");
      end
      @(negedge clk);
      chk(!res_valid_o, "R2 result lasts one cycle", 32'(res_valid_o), 32'd0);

      // R5: FIFO replaces earliest load (idx0) despite its recent hit
      policy_i = 1'b0;
      do_fill(8'h55, 16'h5555, 1'b0, 8'h00, 16'h0, "R5 fifo fill");
      do_lookup(8'h55, 1'b1, 2'd0, 16'h5555, "R5 new key at idx0");
      do_lookup(8'h11, 1'b0, 2'd0, 16'h0, "R5 oldest load evicted");

      // R6/R11: switch to LRU, refresh idx1, oldest recency is idx3
      policy_i = 1'b1;
      do_lookup(8'h22, 1'b1, 2'd1, 16'h0B22, "R6 refresh hit");
      do_fill(8'h66, 16'h6666, 1'b0, 8'h00, 16'h0, "R11 lru fill");
      do_lookup(8'h66, 1'b1, 2'd3, 16'h6666, "R6 lru victim idx3");
      do_lookup(8'h44, 1'b0, 2'd0, 16'h0, "R11 lru evicted 44");

      // R7: write to cached key and to absent key
      do_write(8'h22, 16'hBEEF);
      do_lookup(8'h22, 1'b1, 2'd1, 16'hBEEF, "R7 write updates payload");
      do_write(8'h99, 16'hDEAD);
      do_lookup(8'h99, 1'b0, 2'd0, 16'h0, "R7 write to absent key ignored");

      // R8: dirty victim (33 at idx2 is LRU) is written back
      do_write(8'h33, 16'hC0DE);
      do_fill(8'h77, 16'h7777, 1'b1, 8'h33, 16'hC0DE, "R8 dirty write-back");
      do_fill(8'h88, 16'h8888, 1'b0, 8'h00, 16'h0, "R8 clean victim silent");
      do_lookup(8'h88, 1'b1, 2'd0, 16'h8888, "R8 clean victim replaced idx0");

      // R10: lookup and write to same key in one cycle
      lk_valid_i = 1'b1; lk_key_i = 8'h22;
      wr_valid_i = 1'b1; wr_key_i = 8'h22; wr_data_i = 16'h1234;
      @(negedge clk);
      lk_valid_i = 1'b0; wr_valid_i = 1'b0;
      chk(res_hit_o && res_data_o == 16'hBEEF, "R10 old payload", 32'(res_data_o), 32'hBEEF);
      do_lookup(8'h22, 1'b1, 2'd1, 16'h1234, "R10 new payload after");

      // R12: lookup hit on LRU entry (idx3) with a fill in the same cycle
      lk_valid_i = 1'b1; lk_key_i = 8'h66;
      fill_valid_i = 1'b1; fill_key_i = 8'h99; fill_data_i = 16'h9999;
      @(negedge clk);
      lk_valid_i = 1'b0; fill_valid_i = 1'b0;
      chk(res_hit_o && res_idx_o == 2'd3 && res_data_o == 16'h6666, "R12 pre-fill answer",
          32'(res_data_o), 32'h6666);
      chk(!wb_valid_o, "R12 clean victim", 32'(wb_valid_o), 32'd0);
      do_lookup(8'h66, 1'b0, 2'd0, 16'h0, "R12 victim chosen before refresh");
      do_lookup(8'h99, 1'b1, 2'd3, 16'h9999, "R12 new key at idx3");

      // R9: duplicate key, lowest index wins
      do_fill(8'h99, 16'hAAAA, 1'b0, 8'h00, 16'h0, "R9 duplicate fill");
      do_lookup(8'h99, 1'b1, 2'd2, 16'hAAAA, "R9 lowest index");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule